// File: doc/BRIEF.md
# Sector-Organised Cache with Per-Block Validity

This block is a small word-addressed cache whose storage is arranged as sector frames. Each frame holds one sector tag and several block frames, and each block frame has its own valid bit. A request's tag is compared against every frame's sector tag at once, so any memory sector can live in any frame. The block field of the address then picks the block frame inside the matching frame, always at the same position the block has inside its memory sector. The block's valid bit decides between hit and miss.

A read miss inside a sector that is already present fetches only the missing block. A read whose sector is absent claims a frame in round-robin order, wipes every block valid bit in that frame, writes the new tag, and then fetches the one block asked for. Writes go straight through to memory; a write that hits also updates the cached word, and a write that misses allocates nothing. One request is in flight at a time: the CPU side sees `req_ready` low while a block fill is outstanding.

A word address is split, from the least significant bit, into a word-in-block field (log2 of words per block), a block-in-sector field (log2 of blocks per sector) and the sector tag in the remaining upper bits. The defaults are 4 frames, 4 blocks per sector, 4 words per block, 16-bit addresses and 32-bit words.

Top module: `scache_sector_ctrl`

## Requirements
- R1: After reset no sector tag and no block is valid: `req_ready` is 1, `rsp_valid`, `mem_req_valid` and `mem_wr_valid` are 0, and the first read of any address is a miss.
- R2: A read that hits returns `rsp_valid`=1, `rsp_hit`=1 and the cached word exactly one cycle after the request is accepted (`req_valid` and `req_ready` both 1), with no memory request.
- R3: A read that misses raises `mem_req_valid` the cycle after acceptance and keeps it, with an unchanged `mem_req_addr`, until `mem_fill_valid` is sampled; `req_ready` is 0 for that whole time.
- R4: The cycle after `mem_fill_valid` is sampled during a fill, `rsp_valid`=1, `rsp_hit`=0 and `rsp_rdata` is the word of `mem_fill_data` at the requested word offset (word w sits in bits w*32 upward).
- R5: `mem_req_addr` is the request address with the word-in-block field dropped; the filled block lands in the block frame whose index is the request's block field, and a miss in a present sector changes no other block of that frame.
- R6: A sector-tag miss takes frames in the order 0,1,2,3,0,...; all blocks previously held in the taken frame become invalid, including blocks of the newly loaded sector other than the one fetched.
- R7: Every accepted write gives `mem_wr_valid`=1 for one cycle, one cycle after acceptance, carrying the request address and data, together with `rsp_valid`=1 whose `rsp_hit` tells whether the word was cached.
- R8: A write hit replaces the cached word and the block stays valid; a write miss allocates no frame and sets no valid bit.
- R9: Any four distinct sectors may be resident at once, in any frames, and all their loaded blocks hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | CPU request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | Request accepted this cycle when high |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_hit | output | 1 | Response served from cache |
| rsp_rdata | output | 32 | Read data |
| mem_req_valid | output | 1 | Block fill requested, held until fill |
| mem_req_addr | output | 14 | Block address of the fill |
| mem_fill_valid | input | 1 | Fill data present |
| mem_fill_data | input | 128 | Whole block, word 0 in the low bits |
| mem_wr_valid | output | 1 | Write-through strobe |
| mem_wr_addr | output | 16 | Write-through word address |
| mem_wr_data | output | 32 | Write-through data |

## Verification
A hit read response and every write response with its write-through strobe are due one cycle after the accepting edge; a miss response is due one cycle after the edge that samples the fill, and the memory request is due one cycle after acceptance. The bench drives inputs on the falling edge, updates a behavioural model on each rising edge from the inputs that edge sampled, and compares every output against that model's prediction on the following falling edge, so each result is checked in exactly the cycle it is due. The fill responder varies its latency between one and three cycles so that the hold of the memory request is exercised over several lengths.

// File: rtl/scache_pkg.sv
package scache_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_FILL = 1'b1
    } scache_state_e;

endpackage

// File: rtl/scache_rr_victim.sv
module scache_rr_victim #(
    parameter int NUM_SECT = 4,
    localparam int SIDX_W = $clog2(NUM_SECT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance,
    output logic [SIDX_W-1:0] victim
);

    logic [SIDX_W-1:0] ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (advance) begin
            ptr_d = (ptr_q == SIDX_W'(NUM_SECT - 1)) ? '0 : ptr_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign victim = ptr_q;

    // R6
    rr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        advance && (victim == SIDX_W'(NUM_SECT - 1)) |=> victim == '0);

    // R6
    rr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> $stable(victim));

endmodule

// File: rtl/scache_tag_lookup.sv
module scache_tag_lookup #(
    parameter int NUM_SECT = 4,
    parameter int TAG_W    = 12,
    localparam int SIDX_W  = $clog2(NUM_SECT)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_SECT*TAG_W-1:0] tags_flat,
    input  logic [NUM_SECT-1:0]       sect_vld,
    input  logic [TAG_W-1:0]          look_tag,
    output logic                      sect_hit,
    output logic [SIDX_W-1:0]         hit_idx
);

    logic [NUM_SECT-1:0] match;

    for (genvar s = 0; s < NUM_SECT; s++) begin : g_cmp
        assign match[s] = sect_vld[s] && (tags_flat[s*TAG_W +: TAG_W] == look_tag);
    end

    always_comb begin
        hit_idx = '0;
        for (int s = 0; s < NUM_SECT; s++) begin
            if (match[s]) hit_idx = SIDX_W'(s);
        end
    end

    assign sect_hit = |match;

    // R9
    tag_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));

endmodule

// File: rtl/scache_store.sv
module scache_store #(
    parameter int NUM_SECT = 4,
    parameter int BLKS     = 4,
    parameter int WORDS    = 4,
    parameter int DATA_W   = 32,
    parameter int TAG_W    = 12,
    localparam int SIDX_W  = $clog2(NUM_SECT),
    localparam int BIDX_W  = $clog2(BLKS),
    localparam int WIDX_W  = $clog2(WORDS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      alloc_en,
    input  logic [SIDX_W-1:0]         alloc_sect,
    input  logic [TAG_W-1:0]          alloc_tag,
    input  logic                      fill_en,
    input  logic [SIDX_W-1:0]         fill_sect,
    input  logic [BIDX_W-1:0]         fill_blk,
    input  logic [WORDS*DATA_W-1:0]   fill_line,
    input  logic                      wr_en,
    input  logic [SIDX_W-1:0]         wr_sect,
    input  logic [BIDX_W-1:0]         wr_blk,
    input  logic [WIDX_W-1:0]         wr_word,
    input  logic [DATA_W-1:0]         wr_data,
    input  logic [SIDX_W-1:0]         rd_sect,
    input  logic [BIDX_W-1:0]         rd_blk,
    input  logic [WIDX_W-1:0]         rd_word,
    output logic [DATA_W-1:0]         rd_data,
    output logic [NUM_SECT*TAG_W-1:0] tags_flat,
    output logic [NUM_SECT-1:0]       sect_vld,
    output logic [NUM_SECT*BLKS-1:0]  blk_vld
);

    typedef struct packed {
        logic [NUM_SECT-1:0][TAG_W-1:0]                     tag;
        logic [NUM_SECT-1:0]                                sv;
        logic [NUM_SECT-1:0][BLKS-1:0]                      bv;
        logic [NUM_SECT-1:0][BLKS-1:0][WORDS-1:0][DATA_W-1:0] data;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (alloc_en) begin
            st_d.tag[alloc_sect] = alloc_tag;
            st_d.sv[alloc_sect]  = 1'b1;
            st_d.bv[alloc_sect]  = '0;
        end
        if (fill_en) begin
            st_d.bv[fill_sect][fill_blk] = 1'b1;
            for (int w = 0; w < WORDS; w++) begin
                st_d.data[fill_sect][fill_blk][w] = fill_line[w*DATA_W +: DATA_W];
            end
        end
        if (wr_en) begin
            st_d.data[wr_sect][wr_blk][wr_word] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data   = st_q.data[rd_sect][rd_blk][rd_word];
    assign tags_flat = st_q.tag;
    assign sect_vld  = st_q.sv;
    assign blk_vld   = st_q.bv;

    // R6
    alloc_wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |=> sect_vld[$past(alloc_sect)] &&
                     (blk_vld[$past(alloc_sect)*BLKS +: BLKS] == '0));

    // R5
    fill_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> blk_vld[{$past(fill_sect), $past(fill_blk)}]);

    // R8
    wr_keeps_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && blk_vld[{wr_sect, wr_blk}] |=> blk_vld[{$past(wr_sect), $past(wr_blk)}]);

endmodule

// File: rtl/scache_sector_ctrl.sv
module scache_sector_ctrl
    import scache_pkg::*;
#(
    parameter int NUM_SECT = 4,
    parameter int BLKS     = 4,
    parameter int WORDS    = 4,
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 32,
    localparam int SIDX_W  = $clog2(NUM_SECT),
    localparam int BIDX_W  = $clog2(BLKS),
    localparam int WIDX_W  = $clog2(WORDS),
    localparam int TAG_W   = ADDR_W - BIDX_W - WIDX_W,
    localparam int BADDR_W = ADDR_W - WIDX_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic                    req_write,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [DATA_W-1:0]       req_wdata,
    output logic                    req_ready,
    output logic                    rsp_valid,
    output logic                    rsp_hit,
    output logic [DATA_W-1:0]       rsp_rdata,
    output logic                    mem_req_valid,
    output logic [BADDR_W-1:0]      mem_req_addr,
    input  logic                    mem_fill_valid,
    input  logic [WORDS*DATA_W-1:0] mem_fill_data,
    output logic                    mem_wr_valid,
    output logic [ADDR_W-1:0]       mem_wr_addr,
    output logic [DATA_W-1:0]       mem_wr_data
);

    typedef struct packed {
        scache_state_e       st;
        logic [ADDR_W-1:0]   addr;
        logic [SIDX_W-1:0]   sect;
        logic                rsp_v;
        logic                rsp_hit;
        logic [DATA_W-1:0]   rsp_data;
        logic                wr_v;
        logic [ADDR_W-1:0]   wr_addr;
        logic [DATA_W-1:0]   wr_data;
    } ctrl_t;

    ctrl_t c_d, c_q;

    logic [TAG_W-1:0]          req_tag;
    logic [BIDX_W-1:0]         req_blk;
    logic [WIDX_W-1:0]         req_wd;
    logic                      sect_hit;
    logic [SIDX_W-1:0]         hit_idx;
    logic [SIDX_W-1:0]         victim;
    logic                      advance;
    logic                      alloc_en, fill_en, wr_en;
    logic [DATA_W-1:0]         rd_data;
    logic [NUM_SECT*TAG_W-1:0] tags_flat;
    logic [NUM_SECT-1:0]       sect_vld;
    logic [NUM_SECT*BLKS-1:0]  blk_vld;
    logic                      blk_hit;
    logic                      accept;
    logic [DATA_W-1:0]         fill_word;

    assign req_wd  = req_addr[WIDX_W-1:0];
    assign req_blk = req_addr[WIDX_W +: BIDX_W];
    assign req_tag = req_addr[ADDR_W-1 -: TAG_W];
    assign accept  = req_valid && (c_q.st == ST_IDLE);
    assign blk_hit = sect_hit && blk_vld[{hit_idx, req_blk}];

    scache_tag_lookup #(.NUM_SECT(NUM_SECT), .TAG_W(TAG_W)) i_lookup (
        .clk      (clk),
        .rst_n    (rst_n),
        .tags_flat(tags_flat),
        .sect_vld (sect_vld),
        .look_tag (req_tag),
        .sect_hit (sect_hit),
        .hit_idx  (hit_idx)
    );

    scache_rr_victim #(.NUM_SECT(NUM_SECT)) i_victim (
        .clk    (clk),
        .rst_n  (rst_n),
        .advance(advance),
        .victim (victim)
    );

    scache_store #(
        .NUM_SECT(NUM_SECT), .BLKS(BLKS), .WORDS(WORDS),
        .DATA_W(DATA_W), .TAG_W(TAG_W)
    ) i_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .alloc_en  (alloc_en),
        .alloc_sect(victim),
        .alloc_tag (req_tag),
        .fill_en   (fill_en),
        .fill_sect (c_q.sect),
        .fill_blk  (c_q.addr[WIDX_W +: BIDX_W]),
        .fill_line (mem_fill_data),
        .wr_en     (wr_en),
        .wr_sect   (hit_idx),
        .wr_blk    (req_blk),
        .wr_word   (req_wd),
        .wr_data   (req_wdata),
        .rd_sect   (hit_idx),
        .rd_blk    (req_blk),
        .rd_word   (req_wd),
        .rd_data   (rd_data),
        .tags_flat (tags_flat),
        .sect_vld  (sect_vld),
        .blk_vld   (blk_vld)
    );

    always_comb begin
        fill_word = '0;
        for (int w = 0; w < WORDS; w++) begin
            if (c_q.addr[WIDX_W-1:0] == WIDX_W'(w)) fill_word = mem_fill_data[w*DATA_W +: DATA_W];
        end
    end

    always_comb begin
        c_d      = c_q;
        c_d.rsp_v = 1'b0;
        c_d.wr_v  = 1'b0;
        alloc_en = 1'b0;
        advance  = 1'b0;
        fill_en  = 1'b0;
        wr_en    = 1'b0;
        case (c_q.st)
            ST_IDLE: begin
                if (accept) begin
                    if (req_write) begin
                        c_d.wr_v     = 1'b1;
                        c_d.wr_addr  = req_addr;
                        c_d.wr_data  = req_wdata;
                        c_d.rsp_v    = 1'b1;
                        c_d.rsp_hit  = blk_hit;
                        c_d.rsp_data = '0;
                        wr_en        = blk_hit;
                    end else if (blk_hit) begin
                        c_d.rsp_v    = 1'b1;
                        c_d.rsp_hit  = 1'b1;
                        c_d.rsp_data = rd_data;
                    end else begin
                        c_d.st   = ST_FILL;
                        c_d.addr = req_addr;
                        c_d.sect = sect_hit ? hit_idx : victim;
                        alloc_en = !sect_hit;
                        advance  = !sect_hit;
                    end
                end
            end
            ST_FILL: begin
                if (mem_fill_valid) begin
                    fill_en      = 1'b1;
                    c_d.st       = ST_IDLE;
                    c_d.rsp_v    = 1'b1;
                    c_d.rsp_hit  = 1'b0;
                    c_d.rsp_data = fill_word;
                end
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign req_ready     = (c_q.st == ST_IDLE);
    assign rsp_valid     = c_q.rsp_v;
    assign rsp_hit       = c_q.rsp_hit;
    assign rsp_rdata     = c_q.rsp_data;
    assign mem_req_valid = (c_q.st == ST_FILL);
    assign mem_req_addr  = c_q.addr[ADDR_W-1:WIDX_W];
    assign mem_wr_valid  = c_q.wr_v;
    assign mem_wr_addr   = c_q.wr_addr;
    assign mem_wr_data   = c_q.wr_data;

    // R3
    mem_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_fill_valid |=> mem_req_valid && $stable(mem_req_addr));

    // R3
    busy_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready);

    // R7
    wt_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_valid |-> $past(req_valid && req_ready && req_write));

    // R2
    rsp_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past((req_valid && req_ready) || (mem_req_valid && mem_fill_valid)));

    // R4
    fill_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && mem_fill_valid |=> rsp_valid && !rsp_hit);

endmodule

// File: tb/test_scache_sector_ctrl.sv
module test_scache_sector_ctrl;

    localparam int NS = 4;
    localparam int NB = 4;
    localparam int NW = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_write = 1'b0;
    logic [15:0]  req_addr = '0;
    logic [31:0]  req_wdata = '0;
    logic         req_ready;
    logic         rsp_valid, rsp_hit;
    logic [31:0]  rsp_rdata;
    logic         mem_req_valid;
    logic [13:0]  mem_req_addr;
    logic         mem_fill_valid = 1'b0;
    logic [127:0] mem_fill_data = '0;
    logic         mem_wr_valid;
    logic [15:0]  mem_wr_addr;
    logic [31:0]  mem_wr_data;

    int n_chk = 0;
    int n_err = 0;
    bit chk_on = 1'b0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    scache_sector_ctrl i_scache_sector_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_rdata(rsp_rdata),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_fill_valid(mem_fill_valid), .mem_fill_data(mem_fill_data),
        .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data)
    );

    logic [31:0] bmem [int];

    function automatic logic [31:0] mem_rd(int a);
        if (bmem.exists(a)) return bmem[a];
        return (32'(a) * 32'h0100_0193) ^ 32'hA5A5_0000;
    endfunction

    task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // behavioural reference model
    int          m_tag [NS];
    bit          m_sv  [NS];
    bit          m_bv  [NS][NB];
    logic [31:0] m_data[NS][NB][NW];
    int          m_rr, m_sect, m_addr;
    bit          m_fill;
    bit          e_ready, e_rv, e_hit, e_wrsp, e_mreq, e_wv;
    logic [31:0] e_data, e_wdata;
    logic [15:0] e_waddr;
    logic [13:0] e_maddr;

    always @(posedge clk) begin
        e_rv = 0;
        e_wv = 0;
        if (!rst_n) begin
            for (int s = 0; s < NS; s++) begin
                m_sv[s] = 0;
                for (int b = 0; b < NB; b++) m_bv[s][b] = 0;
            end
            m_rr = 0;
            m_fill = 0;
        end else if (!m_fill && req_valid) begin
            int tg, bk, wd, fs;
            bit hit;
            tg = int'(req_addr) / (NB * NW);
            bk = (int'(req_addr) / NW) % NB;
            wd = int'(req_addr) % NW;
            fs = -1;
            for (int s = 0; s < NS; s++) if (m_sv[s] && m_tag[s] == tg) fs = s;
            hit = (fs >= 0) && m_bv[fs][bk];
            if (req_write) begin
                e_wv = 1; e_waddr = req_addr; e_wdata = req_wdata;
                bmem[int'(req_addr)] = req_wdata;
                e_rv = 1; e_hit = hit; e_wrsp = 1;
                if (hit) m_data[fs][bk][wd] = req_wdata;
            end else if (hit) begin
                e_rv = 1; e_hit = 1; e_wrsp = 0; e_data = m_data[fs][bk][wd];
            end else begin
                if (fs < 0) begin
                    fs = m_rr;
                    m_rr = (m_rr + 1) % NS;
                    m_tag[fs] = tg;
                    m_sv[fs] = 1;
                    for (int b = 0; b < NB; b++) m_bv[fs][b] = 0;
                end
                m_fill = 1; m_sect = fs; m_addr = int'(req_addr);
            end
        end else if (m_fill && mem_fill_valid) begin
            int bk, wd;
            bk = (m_addr / NW) % NB;
            wd = m_addr % NW;
            for (int w = 0; w < NW; w++) m_data[m_sect][bk][w] = mem_fill_data[w*32 +: 32];
            m_bv[m_sect][bk] = 1;
            e_rv = 1; e_hit = 0; e_wrsp = 0; e_data = m_data[m_sect][bk][wd];
            m_fill = 0;
        end
        e_ready = !m_fill;
        e_mreq  = m_fill;
        e_maddr = 14'(m_addr / NW);
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (chk_on && !done) begin
            chk(req_ready == e_ready, "R3", "req_ready", 64'(req_ready), 64'(e_ready));
            chk(rsp_valid == e_rv, "R2", "rsp_valid", 64'(rsp_valid), 64'(e_rv));
            if (e_rv) begin
                chk(rsp_hit == e_hit, "R4", "rsp_hit", 64'(rsp_hit), 64'(e_hit));
                if (!e_wrsp) chk(rsp_rdata == e_data, "R4", "rsp_rdata", 64'(rsp_rdata), 64'(e_data));
            end
            chk(mem_req_valid == e_mreq, "R3", "mem_req_valid", 64'(mem_req_valid), 64'(e_mreq));
            if (e_mreq) chk(mem_req_addr == e_maddr, "R5", "mem_req_addr", 64'(mem_req_addr), 64'(e_maddr));
            chk(mem_wr_valid == e_wv, "R7", "mem_wr_valid", 64'(mem_wr_valid), 64'(e_wv));
            if (e_wv) begin
                chk(mem_wr_addr == e_waddr, "R7", "mem_wr_addr", 64'(mem_wr_addr), 64'(e_waddr));
                chk(mem_wr_data == e_wdata, "R7", "mem_wr_data", 64'(mem_wr_data), 64'(e_wdata));
            end
        end
    end

    // memory fill responder with rotating latency
    initial begin
        int lat = 1;
        forever begin
            @(negedge clk);
            if (mem_req_valid && !mem_fill_valid) begin
                repeat (lat - 1) @(negedge clk);
                for (int w = 0; w < NW; w++)
                    mem_fill_data[w*32 +: 32] = mem_rd(int'(mem_req_addr) * NW + w);
                mem_fill_valid = 1'b1;
                @(negedge clk);
                mem_fill_valid = 1'b0;
                lat = (lat % 3) + 1;
            end
        end
    end

    task automatic access(bit wr, logic [15:0] a, logic [31:0] d, bit exp_hit, string req);
        int guard = 0;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_valid && guard < 50) begin
            @(negedge clk);
            guard++;
        end
        chk(rsp_valid, req, "response arrives", 64'(rsp_valid), 64'd1);
        chk(rsp_hit == exp_hit, req, "hit flag", 64'(rsp_hit), 64'(exp_hit));
        if (!wr) chk(rsp_rdata == mem_rd(int'(a)), req, "read data", 64'(rsp_rdata), 64'(mem_rd(int'(a))));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual expired expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_on = 1'b1;
        // R1 reset state
        chk(req_ready == 1'b1, "R1", "req_ready after reset", 64'(req_ready), 64'd1);
        chk(rsp_valid == 1'b0, "R1", "rsp_valid after reset", 64'(rsp_valid), 64'd0);
        chk(mem_req_valid == 1'b0, "R1", "mem_req_valid after reset", 64'(mem_req_valid), 64'd0);
        chk(mem_wr_valid == 1'b0, "R1", "mem_wr_valid after reset", 64'(mem_wr_valid), 64'd0);
        access(0, 16'h0015, 0, 0, "R1");
        access(0, 16'h0016, 0, 1, "R2");
        access(0, 16'h0014, 0, 1, "R2");
        // R5: other block of a present sector misses, neighbours stay
        access(0, 16'h001A, 0, 0, "R5");
        access(0, 16'h0015, 0, 1, "R5");
        access(0, 16'h001B, 0, 1, "R5");
        // R9: four sectors resident together
        access(0, 16'h0020, 0, 0, "R9");
        access(0, 16'h0030, 0, 0, "R9");
        access(0, 16'h0040, 0, 0, "R9");
        access(0, 16'h0017, 0, 1, "R9");
        access(0, 16'h0021, 0, 1, "R9");
        access(0, 16'h0032, 0, 1, "R9");
        access(0, 16'h0043, 0, 1, "R9");
        // R6: round-robin eviction and wipe
        access(0, 16'h0050, 0, 0, "R6");
        access(0, 16'h0015, 0, 0, "R6");
        access(0, 16'h001A, 0, 0, "R6");
        access(0, 16'h0022, 0, 0, "R6");
        access(0, 16'h0031, 0, 0, "R6");
        access(0, 16'h0051, 0, 1, "R6");
        // R7, R8: write hit updates cache
        access(1, 16'h0031, 32'hDEAD_BEEF, 1, "R8");
        access(0, 16'h0031, 0, 1, "R8");
        access(1, 16'h0777, 32'h1357_9BDF, 0, "R7");
        access(0, 16'h0777, 0, 0, "R8");
        access(1, 16'h003C, 32'h0BAD_F00D, 0, "R8");
        access(0, 16'h003C, 0, 0, "R8");
        access(0, 16'h003D, 0, 1, "R2");
        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule